// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard and bypass control for a five-stage, in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It is purely combinational. Its inputs are the register numbers and the write, load and store flags held in the decode, execute, memory and write-back pipeline registers. Its outputs are the operand bypass selects for the execute stage, a store-data bypass select for the memory stage, and the controls that hold the front end and insert a bubble.

Both execute operands get a two-bit select. The select chooses the register-file value, the result that waits in the memory-stage register, or the result that waits in the write-back-stage register. The newer result wins when both match. Register 0 is never a bypass source, and neither is a stage whose write flag is clear. ALU results can be bypassed as soon as they reach the memory-stage register, so dependent ALU instructions run back to back. Load data first exists in the write-back-stage register. An instruction that needs loaded data in the execute stage, either as an ALU operand or as a store address base, must therefore wait one cycle. During that cycle the program counter and the decode register hold their values, and the execute register receives a no-op. A store whose data register is the loaded register does not wait. Its data is bypassed from the write-back-stage register when the store reaches the memory stage.

The block has no states. The pipeline's cycle-to-cycle behaviour comes from the pipeline registers that surround it.

Top module: `hzd_ctrl`

## Requirements
- R1: `byp_a_sel` is 2'b01 (take the memory-stage result) when `mem_wr` is 1, `mem_rd` is not 0 and `mem_rd` equals `ex_rs1`.
- R2: `byp_a_sel` is 2'b10 (take the write-back-stage result) when `wb_wr` is 1, `wb_rd` is not 0, `wb_rd` equals `ex_rs1`, and the R1 condition does not hold.
- R3: `byp_b_sel` follows the R1 and R2 rules with `ex_rs2` in place of `ex_rs1`. The code 2'b11 never appears on either select.
- R4: When the memory stage and the write-back stage both match the same source, the select is 2'b01.
- R5: A select is 2'b00 (register-file value) whenever no stage qualifies. A stage does not qualify when its write flag is 0 or its destination is register 0.
- R6: `pc_hold`, `ifid_hold` and `idex_bubble` are 1 when `ex_load` and `ex_wr` are 1, `ex_rd` is not 0, and `ex_rd` equals a decode source that is read. `dec_rs1` is read when `dec_rd_rs1` is 1. `dec_rs2` is read when `dec_rd_rs2` is 1 and `dec_is_store` is 0.
- R7: A decode-stage store (`dec_is_store`=1) whose data register `dec_rs2` equals the loaded register does not stall. A store whose base `dec_rs1` equals the loaded register does stall.
- R8: A decode source whose read flag is 0 never causes a stall, whatever its register number.
- R9: `st_data_from_wb` is 1 exactly when `mem_store`, `wb_wr` and `wb_load` are 1, `wb_rd` is not 0 and `wb_rd` equals `mem_rs2`.
- R10: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal. An ALU result in the execute stage (`ex_load`=0) never stalls.
- R11: A load whose destination is register 0 never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | 5 | First source register of the decode-stage instruction |
| dec_rs2 | input | 5 | Second source register of the decode-stage instruction |
| dec_rd_rs1 | input | 1 | Decode-stage instruction reads its first source |
| dec_rd_rs2 | input | 1 | Decode-stage instruction reads its second source |
| dec_is_store | input | 1 | Decode-stage instruction is a store (second source is store data) |
| ex_rs1 | input | 5 | First source register in the execute stage |
| ex_rs2 | input | 5 | Second source register in the execute stage |
| ex_rd | input | 5 | Destination register in the execute stage |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination register in the memory stage |
| mem_rs2 | input | 5 | Store data register in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | 5 | Destination register in the write-back stage |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| wb_load | input | 1 | Write-back-stage instruction is a load |
| byp_a_sel | output | 2 | First execute operand source: 00 register file, 01 memory stage, 10 write-back stage |
| byp_b_sel | output | 2 | Second execute operand source, same encoding |
| st_data_from_wb | output | 1 | Memory-stage store takes its data from the write-back stage |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the decode pipeline register |
| idex_bubble | output | 1 | Load a no-op into the execute pipeline register |

## Verification
The checker's immediate assertions are evaluated only while every input carries a known value. They accept any combination of flags, so they do not require a load to also set its write flag, and they do not require a store to avoid writing a register. The bench drives every input to a defined value from time zero and changes inputs only from its tasks. Its table and sweeps also use flag combinations that a real decoder would not produce, so that each qualifying term is tested on its own.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

    // Source encoding shared by both execute operand selects
    typedef enum logic [1:0] {
        BYP_REGFILE  = 2'b00,
        BYP_FROM_MEM = 2'b01,
        BYP_FROM_WB  = 2'b10
    } byp_sel_e;

    // Number of register sources per instruction and the one that carries store data
    localparam int unsigned NUM_SRC   = 2;
    localparam int unsigned SDATA_IDX = 1;

endpackage

// File: rtl/hzd_writer_match.sv
`timescale 1ns/1ps
// One producer/consumer comparison: the producer writes a non-zero register equal to the source.
module hzd_writer_match #(
    parameter int unsigned RAW = 5
) (
    input  logic           wr_en,
    input  logic [RAW-1:0] dst,
    input  logic [RAW-1:0] src,
    output logic           hit
);

    localparam logic [RAW-1:0] ZERO_REG = '0;

    assign hit = wr_en && (dst != ZERO_REG) && (dst == src);

endmodule

// File: rtl/hzd_operand_mux.sv
`timescale 1ns/1ps
// Chooses the bypass source of one execute operand, newer result first.
module hzd_operand_mux
    import hzd_pkg::*;
#(
    parameter int unsigned RAW = 5
) (
    input  logic           [RAW-1:0] src,
    input  logic                     mem_wr,
    input  logic           [RAW-1:0] mem_rd,
    input  logic                     wb_wr,
    input  logic           [RAW-1:0] wb_rd,
    output byp_sel_e                 sel
);

    logic mem_hit;
    logic wb_hit;

    hzd_writer_match #(.RAW(RAW)) u_mem_cmp (
        .wr_en (mem_wr),
        .dst   (mem_rd),
        .src   (src),
        .hit   (mem_hit)
    );

    hzd_writer_match #(.RAW(RAW)) u_wb_cmp (
        .wr_en (wb_wr),
        .dst   (wb_rd),
        .src   (src),
        .hit   (wb_hit)
    );

    always_comb begin
        unique casez ({mem_hit, wb_hit})
            2'b1?:   sel = BYP_FROM_MEM;
            2'b01:   sel = BYP_FROM_WB;
            2'b00:   sel = BYP_REGFILE;
            default: sel = BYP_REGFILE;
        endcase
    end

endmodule

// File: rtl/hzd_load_interlock.sv
`timescale 1ns/1ps
// Detects an execute-stage load whose result a decode-stage source needs in execute.
module hzd_load_interlock
    import hzd_pkg::*;
#(
    parameter int unsigned RAW = 5
) (
    input  logic [NUM_SRC-1:0][RAW-1:0] src_addr,
    input  logic [NUM_SRC-1:0]          src_reads,
    input  logic                        dec_is_store,
    input  logic [RAW-1:0]              ex_rd,
    input  logic                        ex_wr,
    input  logic                        ex_load,
    output logic                        stall
);

    logic              load_wr;
    logic [NUM_SRC-1:0] need;

    assign load_wr = ex_wr & ex_load;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // The store data source is consumed in the memory stage and is bypassed there
        localparam bit IS_SDATA = (i == SDATA_IDX);
        logic used_in_ex;
        logic m;

        assign used_in_ex = src_reads[i] && !(IS_SDATA && dec_is_store);

        hzd_writer_match #(.RAW(RAW)) u_cmp (
            .wr_en (load_wr),
            .dst   (ex_rd),
            .src   (src_addr[i]),
            .hit   (m)
        );

        assign need[i] = used_in_ex & m;
    end

    assign stall = |need;

endmodule

// File: rtl/hzd_store_bypass.sv
`timescale 1ns/1ps
// Memory-stage store data taken from a load sitting in write-back.
module hzd_store_bypass #(
    parameter int unsigned RAW = 5
) (
    input  logic           mem_store,
    input  logic [RAW-1:0] mem_rs2,
    input  logic           wb_wr,
    input  logic           wb_load,
    input  logic [RAW-1:0] wb_rd,
    output logic           take_wb
);

    logic hit;

    hzd_writer_match #(.RAW(RAW)) u_cmp (
        .wr_en (wb_wr & wb_load),
        .dst   (wb_rd),
        .src   (mem_rs2),
        .hit   (hit)
    );

    assign take_wb = mem_store & hit;

endmodule

// File: rtl/hzd_ctrl.sv
`timescale 1ns/1ps
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int unsigned RAW = 5
) (
    input  logic [RAW-1:0] dec_rs1,
    input  logic [RAW-1:0] dec_rs2,
    input  logic           dec_rd_rs1,
    input  logic           dec_rd_rs2,
    input  logic           dec_is_store,
    input  logic [RAW-1:0] ex_rs1,
    input  logic [RAW-1:0] ex_rs2,
    input  logic [RAW-1:0] ex_rd,
    input  logic           ex_wr,
    input  logic           ex_load,
    input  logic [RAW-1:0] mem_rd,
    input  logic [RAW-1:0] mem_rs2,
    input  logic           mem_wr,
    input  logic           mem_store,
    input  logic [RAW-1:0] wb_rd,
    input  logic           wb_wr,
    input  logic           wb_load,
    output logic [1:0]     byp_a_sel,
    output logic [1:0]     byp_b_sel,
    output logic           st_data_from_wb,
    output logic           pc_hold,
    output logic           ifid_hold,
    output logic           idex_bubble
);

    logic [NUM_SRC-1:0][RAW-1:0] ex_src;
    logic [NUM_SRC-1:0][RAW-1:0] dec_src;
    logic [NUM_SRC-1:0]          dec_reads;
    byp_sel_e                    op_sel [NUM_SRC];
    logic                        stall;

    assign ex_src    = {ex_rs2, ex_rs1};
    assign dec_src   = {dec_rs2, dec_rs1};
    assign dec_reads = {dec_rd_rs2, dec_rd_rs1};

    // One bypass selector per execute operand
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_op
        hzd_operand_mux #(.RAW(RAW)) u_mux (
            .src    (ex_src[k]),
            .mem_wr (mem_wr),
            .mem_rd (mem_rd),
            .wb_wr  (wb_wr),
            .wb_rd  (wb_rd),
            .sel    (op_sel[k])
        );
    end

    assign byp_a_sel = op_sel[0];
    assign byp_b_sel = op_sel[1];

    hzd_load_interlock #(.RAW(RAW)) u_ilk (
        .src_addr     (dec_src),
        .src_reads    (dec_reads),
        .dec_is_store (dec_is_store),
        .ex_rd        (ex_rd),
        .ex_wr        (ex_wr),
        .ex_load      (ex_load),
        .stall        (stall)
    );

    hzd_store_bypass #(.RAW(RAW)) u_stb (
        .mem_store (mem_store),
        .mem_rs2   (mem_rs2),
        .wb_wr     (wb_wr),
        .wb_load   (wb_load),
        .wb_rd     (wb_rd),
        .take_wb   (st_data_from_wb)
    );

    // Freeze the front end and bubble execute for the one interlock cycle
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;

endmodule

// File: rtl/hzd_ctrl_chk.sv
`timescale 1ns/1ps
module hzd_ctrl_chk #(
    parameter int unsigned RAW = 5
) (
    input logic           dec_rd_rs1,
    input logic           dec_rd_rs2,
    input logic [RAW-1:0] ex_rs1,
    input logic [RAW-1:0] ex_rd,
    input logic           ex_wr,
    input logic           ex_load,
    input logic [RAW-1:0] mem_rd,
    input logic [RAW-1:0] mem_rs2,
    input logic           mem_wr,
    input logic           mem_store,
    input logic [RAW-1:0] wb_rd,
    input logic           wb_wr,
    input logic           wb_load,
    input logic [1:0]     byp_a_sel,
    input logic [1:0]     byp_b_sel,
    input logic           st_data_from_wb,
    input logic           pc_hold,
    input logic           ifid_hold,
    input logic           idex_bubble
);

    localparam logic [RAW-1:0] ZR = '0;

    logic known;
    logic mem_a_match;

    assign known = !$isunknown({dec_rd_rs1, dec_rd_rs2, ex_rs1, ex_rd, ex_wr, ex_load,
                                mem_rd, mem_rs2, mem_wr, mem_store, wb_rd, wb_wr, wb_load,
                                byp_a_sel, byp_b_sel, st_data_from_wb,
                                pc_hold, ifid_hold, idex_bubble});
    assign mem_a_match = mem_wr && (mem_rd != ZR) && (mem_rd == ex_rs1);

    always_comb begin
        if (known) begin
            AST_A_MEM_SOURCE_LIVE: assert (byp_a_sel != 2'b01 || mem_a_match)
                else $error("operand A took memory stage without a live match"); // R1
            AST_A_WB_YIELDS: assert (byp_a_sel != 2'b10 || (wb_wr && wb_rd != ZR && !mem_a_match))
                else $error("operand A took write-back while memory stage matched"); // R4
            AST_SEL_CODE_LEGAL: assert (byp_a_sel != 2'b11 && byp_b_sel != 2'b11)
                else $error("illegal bypass select code"); // R3
            AST_B_NO_DEAD_SOURCE: assert ((byp_b_sel != 2'b01 || (mem_wr && mem_rd != ZR)) &&
                                          (byp_b_sel != 2'b10 || (wb_wr && wb_rd != ZR)))
                else $error("operand B bypassed from a non-writing stage"); // R5
            AST_HOLD_TRIO: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
                else $error("stall controls disagree"); // R10
            AST_STALL_NEEDS_LOAD: assert (!pc_hold || (ex_load && ex_wr && ex_rd != ZR))
                else $error("stall without a live load in execute"); // R11
            AST_IDLE_SOURCES: assert (dec_rd_rs1 || dec_rd_rs2 || !pc_hold)
                else $error("stall with no source read"); // R8
            AST_STDATA_FROM_LOAD: assert (!st_data_from_wb ||
                                          (mem_store && wb_load && wb_wr && wb_rd == mem_rs2))
                else $error("store data bypass without load match"); // R9
        end
    end

endmodule

bind hzd_ctrl hzd_ctrl_chk #(.RAW(RAW)) chk_i (.*);

// File: tb/hzd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hzd_ctrl_tb_top;

    localparam int RAW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [RAW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic dec_rd_rs1, dec_rd_rs2, dec_is_store, ex_wr, ex_load, mem_wr, mem_store, wb_wr, wb_load;
    logic [1:0] byp_a_sel, byp_b_sel;
    logic st_data_from_wb, pc_hold, ifid_hold, idex_bubble;

    int n_chk  = 0;
    int n_bad  = 0;
    bit finished = 1'b0;

    hzd_ctrl #(.RAW(RAW)) dut_i (.*);

    typedef struct packed {
        logic [4:0] d1; logic [4:0] d2; logic u1; logic u2; logic dst;
        logic [4:0] e1; logic [4:0] e2; logic [4:0] erd; logic ewr; logic eld;
        logic [4:0] mrd; logic [4:0] mrs2; logic mwr; logic mst;
        logic [4:0] wrd; logic wwr; logic wld;
        logic [1:0] xa; logic [1:0] xb; logic xst; logic xstall;
    } vec_t;

    localparam int NV = 18;
    // Fields: d1 d2 u1 u2 dst | e1 e2 erd ewr eld | mrd mrs2 mwr mst | wrd wwr wld | xa xb xst xstall
    localparam vec_t VEC [NV] = '{
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R5 idle
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd3, 5'd4, 5'd0, 1'b0,1'b0, 5'd3, 5'd0, 1'b1,1'b0, 5'd0, 1'b0,1'b0, 2'b01,2'b00,1'b0,1'b0}, // R1
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd6, 5'd8, 5'd0, 1'b0,1'b0, 5'd7, 5'd0, 1'b1,1'b0, 5'd6, 1'b1,1'b0, 2'b10,2'b00,1'b0,1'b0}, // R2
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd1, 5'd9, 5'd0, 1'b0,1'b0, 5'd9, 5'd0, 1'b1,1'b0, 5'd1, 1'b1,1'b0, 2'b10,2'b01,1'b0,1'b0}, // R3
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd5, 5'd5, 5'd0, 1'b0,1'b0, 5'd5, 5'd0, 1'b1,1'b0, 5'd5, 1'b1,1'b0, 2'b01,2'b01,1'b0,1'b0}, // R4
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd10,5'd11,5'd0, 1'b0,1'b0, 5'd10,5'd0, 1'b0,1'b0, 5'd11,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R5 flag clear
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd0, 1'b1,1'b0, 5'd0, 1'b1,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R5 dest zero
        '{5'd2, 5'd0, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd2, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b1}, // R6 rs1
        '{5'd12,5'd2, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd2, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b1}, // R6 rs2
        '{5'd12,5'd2, 1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd2, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R7 store data
        '{5'd2, 5'd12,1'b1,1'b1,1'b1, 5'd0, 5'd0, 5'd2, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b1}, // R7 store base
        '{5'd2, 5'd2, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd2, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R8
        '{5'd2, 5'd0, 1'b1,1'b0,1'b0, 5'd0, 5'd0, 5'd2, 1'b1,1'b0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R10 ALU
        '{5'd0, 5'd0, 1'b1,1'b1,1'b0, 5'd0, 5'd0, 5'd0, 1'b1,1'b1, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R11
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd14,1'b0,1'b1, 5'd14,1'b1,1'b1, 2'b00,2'b00,1'b1,1'b0}, // R9 hit
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd14,1'b0,1'b0, 5'd14,1'b1,1'b1, 2'b00,2'b00,1'b0,1'b0}, // R9 no store
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd14,1'b0,1'b1, 5'd14,1'b1,1'b0, 2'b00,2'b00,1'b0,1'b0}, // R9 not load
        '{5'd0, 5'd0, 1'b0,1'b0,1'b0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0, 5'd0, 5'd0, 1'b0,1'b1, 5'd0, 1'b1,1'b1, 2'b00,2'b00,1'b0,1'b0}  // R9 reg zero
    };

    function automatic string vname(int i);
        case (i)
            0: return "R5 idle";           1: return "R1 mem to A";
            2: return "R2 wb to A";        3: return "R3 operand B";
            4: return "R4 priority";       5: return "R5 flag clear";
            6: return "R5 dest zero";      7: return "R6 load-use rs1";
            8: return "R6 load-use rs2";   9: return "R7 store data";
            10: return "R7 store base";    11: return "R8 unread sources";
            12: return "R10 ALU no stall"; 13: return "R11 load to x0";
            14: return "R9 store bypass";  15: return "R9 no store";
            16: return "R9 not a load";    default: return "R9 register zero";
        endcase
    endfunction

    task automatic drive(vec_t v);
        dec_rs1 = v.d1; dec_rs2 = v.d2; dec_rd_rs1 = v.u1; dec_rd_rs2 = v.u2; dec_is_store = v.dst;
        ex_rs1 = v.e1; ex_rs2 = v.e2; ex_rd = v.erd; ex_wr = v.ewr; ex_load = v.eld;
        mem_rd = v.mrd; mem_rs2 = v.mrs2; mem_wr = v.mwr; mem_store = v.mst;
        wb_rd = v.wrd; wb_wr = v.wwr; wb_load = v.wld;
    endtask

    task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got a=%b b=%b st=%b hold=%b%b%b expected a=%b b=%b st=%b hold=%b%b%b",
                     tag, got[6:5], got[4:3], got[2], got[1], got[0], got[0],
                     exp[6:5], exp[4:3], exp[2], exp[1], exp[0], exp[0]);
        end
    endtask

    // Outputs packed as {a, b, st, pc_hold, stall-agreement folded into bit 0}
    function automatic logic [6:0] outs();
        logic trio;
        trio = (pc_hold == ifid_hold && ifid_hold == idex_bubble) ? pc_hold : 1'bx;
        return {byp_a_sel, byp_b_sel, st_data_from_wb, pc_hold, trio};
    endfunction

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        vec_t z;
        z = '0;
        drive(z);
        settle();
        // Idle state with every flag clear: no bypass, no stall (R5, R10)
        check("R5 idle outputs", outs(), 7'b0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            drive(VEC[i]);
            @(negedge clk);
            check(vname(i), outs(), {VEC[i].xa, VEC[i].xb, VEC[i].xst, VEC[i].xstall, VEC[i].xstall});
        end

        // Operand A sweep over small register numbers and both write flags (R1 R2 R4 R5)
        for (int ea = 0; ea < 4; ea++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 4; w++)
                    for (int fl = 0; fl < 4; fl++) begin
                        logic [1:0] ea_exp;
                        logic mq, wq;
                        z = '0;
                        z.e1 = 5'(ea); z.e2 = 5'(ea);
                        z.mrd = 5'(m); z.mwr = fl[0];
                        z.wrd = 5'(w); z.wwr = fl[1];
                        @(posedge clk);
                        drive(z);
                        @(negedge clk);
                        mq = fl[0] && m != 0 && m == ea;
                        wq = fl[1] && w != 0 && w == ea;
                        ea_exp = mq ? 2'b01 : (wq ? 2'b10 : 2'b00);
                        check("R4 sweep A/B", outs(), {ea_exp, ea_exp, 3'b000});
                    end

        // Interlock sweep on the first source (R6 R8 R11)
        for (int d = 0; d < 4; d++)
            for (int r = 0; r < 4; r++)
                for (int fl = 0; fl < 4; fl++) begin
                    logic s;
                    z = '0;
                    z.d1 = 5'(d); z.u1 = fl[0];
                    z.erd = 5'(r); z.ewr = 1'b1; z.eld = fl[1];
                    @(posedge clk);
                    drive(z);
                    @(negedge clk);
                    s = fl[1] && fl[0] && r != 0 && r == d;
                    check("R6 interlock sweep", outs(), {4'b0000, 1'b0, s, s});
                end

        // Load with write flag clear does not stall (R6)
        z = '0; z.d1 = 5'd4; z.u1 = 1'b1; z.erd = 5'd4; z.eld = 1'b1; z.ewr = 1'b0;
        @(posedge clk); drive(z); @(negedge clk);
        check("R6 load without write", outs(), 7'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule